// File: doc/BRIEF.md
# SIMD Instruction Fault Gate

This block decides, for one packed single-precision SIMD instruction, whether it may go ahead or which fault it must raise. On an evaluation strobe it samples the processor mode, the relevant control bits, the feature-enable bit and a description of the source operand. The operand description covers whether the source is in memory, its effective address and segment, a limit-violation flag from the segmentation unit, and a page-fault flag with its code from the translation unit. It also samples an unmasked-numeric-exception flag from the arithmetic unit.

One clock later it presents a one-hot fault vector and an error code, or an execute permit when no fault applies. The priority among faults is fixed. The segment-limit computation, the page walk and the dispatch to a handler all stay outside the block.

Top module: `simd_fault_gate`

Fault bit positions in `fault_oh`: 0 invalid opcode, 1 device not available, 2 general protection, 3 stack fault, 4 interrupt 13, 5 page fault, 6 SIMD floating-point fault.

Mode encoding: 2'b00 real, 2'b01 virtual-8086, 2'b10 and 2'b11 protected.

Segment encoding: 3'd2 is the stack segment; any other value is a data or code segment.

## Requirements
- R1: If the emulation bit is 1, the OS-save-enable bit is 0 or the feature bit is 0, the result is invalid opcode (bit 0), whatever else is asserted.
- R2: If R1 does not apply and the task-switched bit is 1, the result is device not available (bit 1).
- R3: A memory source whose address has any of its low 4 bits set is a misaligned operand. It raises general protection (bit 2) in protected mode and interrupt 13 (bit 4) in real or virtual-8086 mode, with error code 0. A register source is never checked for alignment.
- R4: In protected mode, an aligned memory source with the limit-violation flag set raises stack fault (bit 3) when the segment code is 2 and general protection (bit 2) otherwise, with error code 0.
- R5: In real and virtual-8086 mode, an aligned memory source with effective address + 15 > 0xFFFF raises interrupt 13 (bit 4). The limit-violation flag has no effect in these modes.
- R6: A memory source with the page-fault flag set raises page fault (bit 5) in protected and virtual-8086 mode, and the error code equals the supplied page-fault code. In real mode the page-fault flag has no effect.
- R7: An unmasked numeric exception raises the SIMD floating-point fault (bit 6) when the OS exception-enable bit is 1, and invalid opcode (bit 0) when it is 0.
- R8: The priority order is: R1, then R2, then the operand faults (R3 before R4 and R5), then R6, then R7. At most one fault bit is set. The execute permit is 1 exactly when no fault bit is set in a valid result.
- R9: The result appears, with `res_vld` high, in the cycle after `eval_vld` is sampled high. In other cycles, and after reset, `res_vld`, `fault_oh`, `err_code` and `exec_ok` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_vld | input | 1 | Evaluate the inputs in this cycle |
| cpu_mode | input | 2 | Processor mode |
| ctl_em | input | 1 | Emulation control bit |
| ctl_ts | input | 1 | Task-switched control bit |
| ctl_osfxsr | input | 1 | OS save/restore enable bit |
| ctl_osxmm | input | 1 | OS unmasked-SIMD-exception enable bit |
| feat_ok | input | 1 | Feature-enable bit of the instruction |
| mem_src | input | 1 | Source operand is in memory |
| eff_addr | input | AW | Effective address of the source |
| seg_code | input | 3 | Segment of the source (2 = stack) |
| lim_viol | input | 1 | Segment limit violated |
| pf_hit | input | 1 | Page fault on the source access |
| pf_code | input | ECW | Page-fault error code |
| num_unmasked | input | 1 | Unmasked numeric exception from the arithmetic unit |
| res_vld | output | 1 | Result valid |
| fault_oh | output | 7 | One-hot fault vector |
| err_code | output | ECW | Error code for the raised fault |
| exec_ok | output | 1 | Instruction may execute |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 16-bit error code and 16-byte alignment. With these settings an address of 0xFFF0 sits exactly at the real-mode top and 0x10000 sits just past it. It sweeps every mode against all 32 combinations of the five control and feature bits. It also crosses memory and register sources, both limit-flag values, both page-flag values, both numeric-flag values, stack and non-stack segments, and four addresses: aligned low, misaligned, last aligned fit and first overflow. This sweep reaches every rung of the priority ladder and every pairing of competing faults.

// File: rtl/simd_fault_pkg.sv
package simd_fault_pkg;
  localparam int unsigned FLT_W = 7;
  localparam int unsigned B_UD  = 0;
  localparam int unsigned B_NM  = 1;
  localparam int unsigned B_GP  = 2;
  localparam int unsigned B_SS  = 3;
  localparam int unsigned B_I13 = 4;
  localparam int unsigned B_PF  = 5;
  localparam int unsigned B_XM  = 6;

  // priority rungs, index 0 is the highest
  localparam int unsigned RUNGS = 5;
  localparam int unsigned RG_CFG = 0;
  localparam int unsigned RG_DEV = 1;
  localparam int unsigned RG_OPD = 2;
  localparam int unsigned RG_PG  = 3;
  localparam int unsigned RG_NUM = 4;

  typedef enum logic [1:0] {
    MODE_REAL = 2'b00,
    MODE_V86  = 2'b01,
    MODE_PROT = 2'b10,
    MODE_PRT2 = 2'b11
  } cpu_mode_e;

  localparam logic [2:0] SEG_STACK = 3'd2;
endpackage

// File: rtl/sfg_ctl_check.sv
module sfg_ctl_check (
  input  logic em,
  input  logic ts,
  input  logic osfxsr,
  input  logic osxmm,
  input  logic feat,
  input  logic num_unmasked,
  output logic cfg_bad,
  output logic dev_na,
  output logic num_req,
  output logic num_as_xm
);
  always_comb begin
    cfg_bad   = em | ~osfxsr | ~feat;
    dev_na    = ts;
    num_req   = num_unmasked;
    num_as_xm = osxmm;
  end
endmodule

// File: rtl/sfg_mem_check.sv
module sfg_mem_check
  import simd_fault_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned ALIGN_LG2 = 4,
  parameter int unsigned RM_TOP    = 32'h0000_FFFF
) (
  input  logic [1:0]    mode,
  input  logic          mem_src,
  input  logic [AW-1:0] ea,
  input  logic [2:0]    seg,
  input  logic          lim_viol,
  input  logic          pf_hit,
  output logic          opd_req,
  output logic [FLT_W-1:0] opd_oh,
  output logic          pg_req
);
  localparam int unsigned SPAN = (1 << ALIGN_LG2) - 1;

  logic          misal;
  logic [AW:0]   ea_end;
  logic          rm_over;
  logic          prot;

  generate
    if (ALIGN_LG2 == 0) begin : g_noalign
      assign misal = 1'b0;
    end else begin : g_align
      assign misal = |ea[ALIGN_LG2-1:0];
    end
  endgenerate

  always_comb begin
    prot    = mode[1];
    ea_end  = {1'b0, ea} + (AW+1)'(SPAN);
    rm_over = ea_end > (AW+1)'(RM_TOP);
    opd_oh  = '0;
    if (mem_src) begin
      if (prot) begin
        if (misal)                             opd_oh[B_GP]  = 1'b1;
        else if (lim_viol && seg == SEG_STACK) opd_oh[B_SS]  = 1'b1;
        else if (lim_viol)                     opd_oh[B_GP]  = 1'b1;
      end else begin
        if (misal || rm_over)                  opd_oh[B_I13] = 1'b1;
      end
    end
    opd_req = |opd_oh;
    pg_req  = mem_src & pf_hit & (mode != MODE_REAL);
  end
endmodule

// File: rtl/sfg_prio.sv
module sfg_prio #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    gnt = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) gnt = '0;
      if (req[i]) gnt[i] = 1'b1;
    end
  end
endmodule

// File: rtl/simd_fault_gate.sv
module simd_fault_gate
  import simd_fault_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned ECW       = 16,
  parameter int unsigned ALIGN_LG2 = 4,
  parameter int unsigned RM_TOP    = 32'h0000_FFFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             eval_vld,
  input  logic [1:0]       cpu_mode,
  input  logic             ctl_em,
  input  logic             ctl_ts,
  input  logic             ctl_osfxsr,
  input  logic             ctl_osxmm,
  input  logic             feat_ok,
  input  logic             mem_src,
  input  logic [AW-1:0]    eff_addr,
  input  logic [2:0]       seg_code,
  input  logic             lim_viol,
  input  logic             pf_hit,
  input  logic [ECW-1:0]   pf_code,
  input  logic             num_unmasked,
  output logic             res_vld,
  output logic [FLT_W-1:0] fault_oh,
  output logic [ECW-1:0]   err_code,
  output logic             exec_ok
);
  logic cfg_bad, dev_na, num_req, num_as_xm;
  logic opd_req, pg_req;
  logic [FLT_W-1:0] opd_oh;
  logic [RUNGS-1:0] req, gnt;
  logic [FLT_W-1:0] nxt_oh;
  logic [ECW-1:0]   nxt_err;

  sfg_ctl_check u_ctl (
    .em(ctl_em), .ts(ctl_ts), .osfxsr(ctl_osfxsr), .osxmm(ctl_osxmm),
    .feat(feat_ok), .num_unmasked(num_unmasked),
    .cfg_bad(cfg_bad), .dev_na(dev_na), .num_req(num_req), .num_as_xm(num_as_xm)
  );

  sfg_mem_check #(.AW(AW), .ALIGN_LG2(ALIGN_LG2), .RM_TOP(RM_TOP)) u_mem (
    .mode(cpu_mode), .mem_src(mem_src), .ea(eff_addr), .seg(seg_code),
    .lim_viol(lim_viol), .pf_hit(pf_hit),
    .opd_req(opd_req), .opd_oh(opd_oh), .pg_req(pg_req)
  );

  always_comb begin
    req         = '0;
    req[RG_CFG] = cfg_bad;
    req[RG_DEV] = dev_na;
    req[RG_OPD] = opd_req;
    req[RG_PG]  = pg_req;
    req[RG_NUM] = num_req;
  end

  sfg_prio #(.N(RUNGS)) u_prio (.req(req), .gnt(gnt));

  always_comb begin
    nxt_oh  = '0;
    nxt_err = '0;
    if (gnt[RG_CFG]) nxt_oh[B_UD] = 1'b1;
    if (gnt[RG_DEV]) nxt_oh[B_NM] = 1'b1;
    if (gnt[RG_OPD]) nxt_oh = opd_oh;
    if (gnt[RG_PG]) begin
      nxt_oh[B_PF] = 1'b1;
      nxt_err      = pf_code;
    end
    if (gnt[RG_NUM]) begin
      if (num_as_xm) nxt_oh[B_XM] = 1'b1;
      else           nxt_oh[B_UD] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld  <= 1'b0;
      fault_oh <= '0;
      err_code <= '0;
      exec_ok  <= 1'b0;
    end else begin
      res_vld  <= eval_vld;
      fault_oh <= eval_vld ? nxt_oh  : '0;
      err_code <= eval_vld ? nxt_err : '0;
      exec_ok  <= eval_vld & ~(|gnt);
    end
  end
endmodule

// File: rtl/sfg_checker.sv
module sfg_checker
  import simd_fault_pkg::*;
#(
  parameter int unsigned ECW = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             eval_vld,
  input logic             ctl_em,
  input logic             ctl_ts,
  input logic             ctl_osfxsr,
  input logic             feat_ok,
  input logic [ECW-1:0]   pf_code,
  input logic             res_vld,
  input logic [FLT_W-1:0] fault_oh,
  input logic [ECW-1:0]   err_code,
  input logic             exec_ok
);
  a_r8_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fault_oh));

  a_r8_permit_excl: assert property (@(posedge clk) disable iff (rst)
    exec_ok |-> (fault_oh == '0 && res_vld));

  a_r9_latency: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (res_vld == $past(eval_vld)));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !res_vld |-> (fault_oh == '0 && err_code == '0 && !exec_ok));

  a_r1_cfg_ud: assert property (@(posedge clk) disable iff (rst)
    (eval_vld && (ctl_em || !ctl_osfxsr || !feat_ok)) |=> fault_oh[B_UD]);

  a_r2_dev_na: assert property (@(posedge clk) disable iff (rst)
    (eval_vld && !ctl_em && ctl_osfxsr && feat_ok && ctl_ts) |=> fault_oh[B_NM]);

  a_r6_pf_code: assert property (@(posedge clk) disable iff (rst)
    (eval_vld) |=> (!fault_oh[B_PF] || err_code == $past(pf_code)));
endmodule

bind simd_fault_gate sfg_checker #(.ECW(ECW)) u_chk (
  .clk(clk), .rst(rst), .eval_vld(eval_vld), .ctl_em(ctl_em), .ctl_ts(ctl_ts),
  .ctl_osfxsr(ctl_osfxsr), .feat_ok(feat_ok), .pf_code(pf_code),
  .res_vld(res_vld), .fault_oh(fault_oh), .err_code(err_code), .exec_ok(exec_ok)
);

// File: tb/simd_fault_gate_tb.sv
module simd_fault_gate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 32;
  localparam int ECW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic eval_vld = 1'b0;
  logic [1:0] cpu_mode = '0;
  logic ctl_em = 0, ctl_ts = 0, ctl_osfxsr = 0, ctl_osxmm = 0, feat_ok = 0;
  logic mem_src = 0;
  logic [AW-1:0] eff_addr = '0;
  logic [2:0] seg_code = '0;
  logic lim_viol = 0, pf_hit = 0, num_unmasked = 0;
  logic [ECW-1:0] pf_code = '0;
  logic res_vld;
  logic [6:0] fault_oh;
  logic [ECW-1:0] err_code;
  logic exec_ok;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_fault_gate #(.AW(AW), .ECW(ECW)) dut_i (
    .clk(clk), .rst(rst), .eval_vld(eval_vld), .cpu_mode(cpu_mode),
    .ctl_em(ctl_em), .ctl_ts(ctl_ts), .ctl_osfxsr(ctl_osfxsr), .ctl_osxmm(ctl_osxmm),
    .feat_ok(feat_ok), .mem_src(mem_src), .eff_addr(eff_addr), .seg_code(seg_code),
    .lim_viol(lim_viol), .pf_hit(pf_hit), .pf_code(pf_code),
    .num_unmasked(num_unmasked), .res_vld(res_vld), .fault_oh(fault_oh),
    .err_code(err_code), .exec_ok(exec_ok)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  // independent reference model built from the requirements
  task automatic model(output logic [6:0] eoh, output logic [ECW-1:0] eerr, output string tag);
    logic prot, misal, over;
    prot  = cpu_mode[1];
    misal = eff_addr[3:0] != 4'h0;
    over  = (64'(eff_addr) + 64'd15) > 64'hFFFF;
    eoh = '0; eerr = '0; tag = "R8 none";
    if (ctl_em || !ctl_osfxsr || !feat_ok) begin
      eoh = 7'b000_0001; tag = "R1";
    end else if (ctl_ts) begin
      eoh = 7'b000_0010; tag = "R2";
    end else if (mem_src && misal) begin
      eoh = prot ? 7'b000_0100 : 7'b001_0000; tag = "R3";
    end else if (mem_src && prot && lim_viol) begin
      eoh = (seg_code == 3'd2) ? 7'b000_1000 : 7'b000_0100; tag = "R4";
    end else if (mem_src && !prot && over) begin
      eoh = 7'b001_0000; tag = "R5";
    end else if (mem_src && pf_hit && cpu_mode != 2'b00) begin
      eoh = 7'b010_0000; eerr = pf_code; tag = "R6";
    end else if (num_unmasked) begin
      eoh = ctl_osxmm ? 7'b100_0000 : 7'b000_0001; tag = "R7";
    end
  endtask

  initial begin
    logic [6:0] eoh;
    logic [ECW-1:0] eerr;
    string tag;
    logic [AW-1:0] addrs [4];
    int k;
    addrs[0] = 32'h0000_1000;
    addrs[1] = 32'h0000_1004;
    addrs[2] = 32'h0000_FFF0;
    addrs[3] = 32'h0001_0000;
    k = 0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset / idle state
    check("R9 reset res_vld", 32'(res_vld), 0);
    check("R9 reset fault_oh", 32'(fault_oh), 0);
    check("R9 reset exec_ok", 32'(exec_ok), 0);

    for (int m = 0; m < 3; m++)
      for (int c = 0; c < 32; c++)
        for (int ms = 0; ms < 2; ms++)
          for (int lv = 0; lv < 2; lv++)
            for (int ph = 0; ph < 2; ph++)
              for (int nu = 0; nu < 2; nu++)
                for (int sg = 1; sg < 3; sg++)
                  for (int ai = 0; ai < 4; ai++) begin
                    cpu_mode     = 2'(m);
                    {ctl_em, ctl_ts, ctl_osfxsr, ctl_osxmm, feat_ok} = 5'(c);
                    mem_src      = ms[0];
                    lim_viol     = lv[0];
                    pf_hit       = ph[0];
                    num_unmasked = nu[0];
                    seg_code     = 3'(sg);
                    eff_addr     = addrs[ai];
                    k++;
                    pf_code      = ECW'(k * 37 + 5);
                    eval_vld     = 1'b1;
                    model(eoh, eerr, tag);
                    @(negedge clk);
                    check({tag, " res_vld"}, 32'(res_vld), 1);
                    check({tag, " fault"}, 32'(fault_oh), 32'(eoh));
                    check({tag, " err"}, 32'(err_code), 32'(eerr));
                    check({"R8 exec ", tag}, 32'(exec_ok), 32'(eoh == 0));
                  end

    // R9: no evaluation gives a quiet output
    eval_vld = 1'b0;
    @(negedge clk);
    check("R9 idle res_vld", 32'(res_vld), 0);
    check("R9 idle fault", 32'(fault_oh), 0);
    check("R9 idle err", 32'(err_code), 0);
    check("R9 idle exec", 32'(exec_ok), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule